// File: doc/BRIEF.md
# Serial Control Register Write Port

This block is the receive side of a three-wire control link: an active-low select, a serial clock and a serial data line. It accepts write-only accesses into a small bank of sixteen-bit control registers. Every access is a 32-bit frame sent most significant bit first. The frame starts with a fixed 12-bit header, then carries a 4-bit register address and a 16-bit value. A frame is applied only when its header matches and its address is one of the eight writable locations. The stored values are brought out as parallel control signals. Two bits of the configuration register are also brought out as separate single-bit controls.

The serial inputs are asynchronous to the block clock. They pass through a synchronizer, and rising edges of the serial clock are detected in the block clock domain. For that to work, the serial clock must run well below the block clock. The port listens only while the mode-enable input is high. The select may stay low across any number of frames. When it does, a new frame begins right after the 32nd bit of the previous one.

Top module: `srw_port`

## Requirements
- R1: After reset, the registers hold these values: configuration (address 1h) 0xB2FF, I offset (2h) 0x007F, I full-scale (3h) 0x807F, Q offset (Ah) 0x007F, Q full-scale (Bh) 0x807F, dual-edge enable (Dh) 0x3FFF, dual-edge coarse (Eh) 0x07FF, dual-edge fine (Fh) 0x007F.
- R2: While select is low and the mode enable is high, a data bit is taken on each rising serial clock edge. A 32-bit frame is formed from, in shift order: 12 header bits equal to 0x001 (eleven 0s first, then a 1), the address (bit 3 first), then the data (bit 15 first). Such a frame writes the data into the addressed register.
- R3: A frame whose first 12 bits differ from 0x001 changes no register and produces no strobe.
- R4: A frame to a reserved address (0h, 4h to 9h, Ch) changes no register and produces no strobe.
- R5: With select held low, a second frame starts on the 33rd serial clock edge, and consecutive frames are each applied.
- R6: Raising select before the 32nd bit discards the partial frame and clears the bit count. The next low period starts with a fresh header.
- R7: While the mode enable is low, serial traffic changes no register and produces no strobe.
- R8: Configuration bits 15:13 always read 1, 0, 1 whatever value is written. `dcs_en` follows configuration bit 12 and `dclk_phase` follows bit 11.
- R9: `wr_stb` is high for exactly one clock per applied frame, with `wr_addr` showing that frame's address.
- R10: Asserting reset after writes returns every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst | input | 1 | synchronous active-high reset |
| ext_en | input | 1 | mode enable; port ignores traffic when low |
| ser_sel_n | input | 1 | active-low frame select |
| ser_clk | input | 1 | serial clock, data taken on rising edge |
| ser_dat | input | 1 | serial data |
| cfg_word | output | 16 | configuration register (1h) |
| i_offset | output | 16 | I channel offset (2h) |
| i_fullscale | output | 16 | I channel full-scale (3h) |
| q_offset | output | 16 | Q channel offset (Ah) |
| q_fullscale | output | 16 | Q channel full-scale (Bh) |
| des_enable | output | 16 | dual-edge sampling enable (Dh) |
| des_coarse | output | 16 | dual-edge coarse adjust (Dh+1 = Eh) |
| des_fine | output | 16 | dual-edge fine adjust (Fh) |
| dcs_en | output | 1 | duty-cycle stabilizer enable, configuration bit 12 |
| dclk_phase | output | 1 | output clock phase select, configuration bit 11 |
| wr_stb | output | 1 | one-clock pulse per applied frame |
| wr_addr | output | 4 | address of the applied frame |

## Verification
Directed frames cover three things. Writes to every mapped address show that the address decode is right. All-zero and all-one data to the configuration register show the forced bits and the two single-bit controls. Headers that differ in the first, middle or last bit show that the whole header is compared, not only its final 1.

Frames to every reserved address separate "accepted but dropped" from "written". Back-to-back frames under one select period show that the bit count wraps at 32 without a select edge. A partial frame cut short by select, followed by a full frame, shows that the counter restarts. Traffic with the mode enable low must leave everything unchanged.

Random frames with random addresses, data and occasionally bad headers are then compared against a model register file kept in the bench.

// File: rtl/srw_pkg.sv
package srw_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int HDR_W    = 12;
    localparam int FRAME_W  = HDR_W + ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int NUM_REGS = 8;
    localparam int SLOT_W   = $clog2(NUM_REGS);

    localparam logic [HDR_W-1:0] HDR_PATTERN = 12'h001;

    // bits of the configuration slot that are fixed whatever is written
    localparam logic [DATA_W-1:0] CFG_FIX_MASK = 16'hE000;
    localparam logic [DATA_W-1:0] CFG_FIX_VAL  = 16'hA000;
    localparam int CFG_DCS_BIT   = 12;
    localparam int CFG_PHASE_BIT = 11;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CFG   = 3'd0,
        SLOT_IOFF  = 3'd1,
        SLOT_IFS   = 3'd2,
        SLOT_QOFF  = 3'd3,
        SLOT_QFS   = 3'd4,
        SLOT_DESEN = 3'd5,
        SLOT_DESCR = 3'd6,
        SLOT_DESFN = 3'd7
    } slot_e;

    typedef struct packed {
        logic  hit;
        slot_e idx;
    } slot_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        slot_e             idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic slot_t addr_decode(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.hit = 1'b1;
        s.idx = SLOT_CFG;
        case (a)
            4'h1: s.idx = SLOT_CFG;
            4'h2: s.idx = SLOT_IOFF;
            4'h3: s.idx = SLOT_IFS;
            4'hA: s.idx = SLOT_QOFF;
            4'hB: s.idx = SLOT_QFS;
            4'hD: s.idx = SLOT_DESEN;
            4'hE: s.idx = SLOT_DESCR;
            4'hF: s.idx = SLOT_DESFN;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] slot_default(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            0:       v = 16'hB2FF;
            1, 3:    v = 16'h007F;
            2, 4:    v = 16'h807F;
            5:       v = 16'h3FFF;
            6:       v = 16'h07FF;
            default: v = 16'h007F;
        endcase
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] slot_fix(input int idx,
                                                   input logic [DATA_W-1:0] d);
        if (idx == 0)
            return (d & ~CFG_FIX_MASK) | CFG_FIX_VAL;
        return d;
    endfunction

endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= {STAGES{rst_val[b]}};
            else
                chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/srw_frame.sv
module srw_frame
    import srw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    sclk_s,
    input  logic    sdat_s,
    input  logic    sel_n_s,
    output wr_req_t req
);
    logic               sclk_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] shreg;

    logic   rise, active, last_bit;
    frame_t frame;
    slot_t  dec;

    assign rise     = sclk_s & ~sclk_d;
    assign active   = en & ~sel_n_s;
    assign last_bit = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign frame    = frame_t'({shreg, sdat_s});
    assign dec      = addr_decode(frame.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            req     <= '0;
        end else begin
            sclk_d  <= sclk_s;
            req.stb <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[FRAME_W-3:0], sdat_s};
                if (last_bit) begin
                    bit_cnt <= '0;
                    if (frame.hdr == HDR_PATTERN && dec.hit) begin
                        req.stb  <= 1'b1;
                        req.addr <= frame.addr;
                        req.idx  <= dec.idx;
                        req.data <= frame.data;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srw_regbank.sv
module srw_regbank
    import srw_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  wr_req_t                           req,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL = slot_default(i);
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= RST_VAL;
            else if (req.stb && req.idx == slot_e'(i))
                regs[i] <= slot_fix(i, req.data);
        end
    end
endmodule

// File: rtl/srw_port.sv
module srw_port
    import srw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_en,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [DATA_W-1:0] cfg_word,
    output logic [DATA_W-1:0] i_offset,
    output logic [DATA_W-1:0] i_fullscale,
    output logic [DATA_W-1:0] q_offset,
    output logic [DATA_W-1:0] q_fullscale,
    output logic [DATA_W-1:0] des_enable,
    output logic [DATA_W-1:0] des_coarse,
    output logic [DATA_W-1:0] des_fine,
    output logic              dcs_en,
    output logic              dclk_phase,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr
);
    logic [2:0] sync_o;
    wr_req_t    req;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    srw_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rst_val (3'b100),
        .din     ({ser_sel_n, ser_clk, ser_dat}),
        .dout    (sync_o)
    );

    srw_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .en      (ext_en),
        .sclk_s  (sync_o[1]),
        .sdat_s  (sync_o[0]),
        .sel_n_s (sync_o[2]),
        .req     (req)
    );

    srw_regbank u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .regs (regs)
    );

    assign cfg_word    = regs[SLOT_CFG];
    assign i_offset    = regs[SLOT_IOFF];
    assign i_fullscale = regs[SLOT_IFS];
    assign q_offset    = regs[SLOT_QOFF];
    assign q_fullscale = regs[SLOT_QFS];
    assign des_enable  = regs[SLOT_DESEN];
    assign des_coarse  = regs[SLOT_DESCR];
    assign des_fine    = regs[SLOT_DESFN];
    assign dcs_en      = regs[SLOT_CFG][CFG_DCS_BIT];
    assign dclk_phase  = regs[SLOT_CFG][CFG_PHASE_BIT];
    assign wr_stb      = req.stb;
    assign wr_addr     = req.addr;
endmodule

// File: rtl/srw_port_chk.sv
module srw_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        ext_en,
    input logic [15:0] cfg_word,
    input logic [15:0] i_offset,
    input logic        wr_stb,
    input logic [3:0]  wr_addr
);
    // R9: strobe lasts a single clock
    a_r9_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4: strobe only ever names a writable address
    a_r4_stb_mapped: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_addr inside {4'h1, 4'h2, 4'h3, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF}));

    // R8: fixed configuration bits
    a_r8_cfg_fixed: assert property (@(posedge clk) disable iff (rst)
        cfg_word[15:13] == 3'b101);

    // R7: no strobe follows a cycle with the port disabled
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(ext_en) |-> !wr_stb);

    // R1 / R10: configuration default right after reset
    a_r1_cfg_default: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_word == 16'hB2FF && i_offset == 16'h007F));

    // R2: registers change only after a strobe
    a_r2_hold_without_stb: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_stb) && !$past(rst)) |-> ($stable(cfg_word) && $stable(i_offset)));
endmodule

bind srw_port srw_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_en   (ext_en),
    .cfg_word (cfg_word),
    .i_offset (i_offset),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr)
);

// File: tb/sim_srw_port.sv
module sim_srw_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_en = 1'b1;
    logic ser_sel_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [15:0] cfg_word, i_offset, i_fullscale, q_offset, q_fullscale;
    logic [15:0] des_enable, des_coarse, des_fine;
    logic dcs_en, dclk_phase, wr_stb;
    logic [3:0] wr_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int stb_seen = 0;
    int stb_exp = 0;
    logic [3:0] last_addr = 4'h0;
    logic [15:0] model [16];
    bit done = 0;

    always #2 clk = ~clk;

    srw_port u0 (.*);

    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_seen++;
            last_addr = wr_addr;
        end
    end

    function automatic bit mapped(input logic [3:0] a);
        return a inside {4'h1, 4'h2, 4'h3, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
    endfunction

    function automatic logic [31:0] mk(input logic [11:0] h, input logic [3:0] a,
                                       input logic [15:0] d);
        return {h, a, d};
    endfunction

    task automatic model_reset();
        model[4'h1] = 16'hB2FF; model[4'h2] = 16'h007F; model[4'h3] = 16'h807F;
        model[4'hA] = 16'h007F; model[4'hB] = 16'h807F; model[4'hD] = 16'h3FFF;
        model[4'hE] = 16'h07FF; model[4'hF] = 16'h007F;
    endtask

    task automatic model_apply(input logic [31:0] f);
        if (f[31:20] == 12'h001 && mapped(f[19:16])) begin
            model[f[19:16]] = (f[19:16] == 4'h1) ? ((f[15:0] & 16'h1FFF) | 16'hA000) : f[15:0];
            stb_exp++;
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cfg"},   cfg_word,    model[4'h1]);
        chk({tag, " ioff"},  i_offset,    model[4'h2]);
        chk({tag, " ifs"},   i_fullscale, model[4'h3]);
        chk({tag, " qoff"},  q_offset,    model[4'hA]);
        chk({tag, " qfs"},   q_fullscale, model[4'hB]);
        chk({tag, " desen"}, des_enable,  model[4'hD]);
        chk({tag, " descr"}, des_coarse,  model[4'hE]);
        chk({tag, " desfn"}, des_fine,    model[4'hF]);
        chk({tag, " R8 dcs"},   16'(dcs_en),     16'(model[4'h1][12]));
        chk({tag, " R8 phase"}, 16'(dclk_phase), 16'(model[4'h1][11]));
        chk({tag, " R9 strobes"}, 16'(stb_seen), 16'(stb_exp));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_dat = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] f, input int nbits);
        @(negedge clk) ser_sel_n = 1'b0;
        for (int i = 31; i > 31 - nbits; i--) send_bit(f[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic release_sel();
        @(negedge clk) ser_sel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] f);
        send_bits(f, 32);
        if (ext_en) model_apply(f);
        release_sel();
    endtask

    initial begin
        logic [3:0] maps [8];
        logic [3:0] rsv [8];
        void'($urandom(32'd4242));
        maps = '{4'h1, 4'h2, 4'h3, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
        rsv  = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hC};
        model_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");

        // R2: each mapped address
        foreach (maps[k]) frame(mk(12'h001, maps[k], 16'h1111 * 16'(k + 1) ^ 16'h5A3C));
        check_all("R2 mapped writes");
        chk("R9 last addr", 16'(last_addr), 16'hF);

        // R8: forced bits and single-bit controls
        frame(mk(12'h001, 4'h1, 16'h0000));
        check_all("R8 cfg zeros");
        frame(mk(12'h001, 4'h1, 16'hFFFF));
        check_all("R8 cfg ones");
        frame(mk(12'h001, 4'h1, 16'h0800));
        check_all("R8 phase only");

        // R3: header errors
        frame(mk(12'h002, 4'h2, 16'hDEAD));
        frame(mk(12'h000, 4'h3, 16'hDEAD));
        frame(mk(12'h801, 4'hA, 16'hDEAD));
        frame(mk(12'h041, 4'hB, 16'hDEAD));
        check_all("R3 bad header");

        // R4: reserved addresses
        foreach (rsv[k]) frame(mk(12'h001, rsv[k], 16'hBEEF));
        check_all("R4 reserved");

        // R5: back-to-back under one select
        begin
            logic [31:0] fa, fb, fc;
            fa = mk(12'h001, 4'h2, 16'h0102);
            fb = mk(12'h001, 4'hE, 16'h0304);
            fc = mk(12'h001, 4'hD, 16'h0506);
            @(negedge clk) ser_sel_n = 1'b0;
            for (int i = 31; i >= 0; i--) send_bit(fa[i]);
            for (int i = 31; i >= 0; i--) send_bit(fb[i]);
            for (int i = 31; i >= 0; i--) send_bit(fc[i]);
            repeat (6) @(negedge clk);
            model_apply(fa); model_apply(fb); model_apply(fc);
            release_sel();
            check_all("R5 back to back");
            chk("R5 last addr", 16'(last_addr), 16'hD);
        end

        // R6: partial frame then full frame
        send_bits(mk(12'h001, 4'h3, 16'hAAAA), 20);
        release_sel();
        check_all("R6 partial dropped");
        frame(mk(12'h001, 4'h3, 16'h4321));
        check_all("R6 fresh frame");
        send_bits(mk(12'h001, 4'hF, 16'h9999), 31);
        release_sel();
        frame(mk(12'h001, 4'hF, 16'h1234));
        check_all("R6 31-bit abort");

        // R7: disabled
        @(negedge clk) ext_en = 1'b0;
        frame(mk(12'h001, 4'h2, 16'hFACE));
        frame(mk(12'h001, 4'h1, 16'h0000));
        check_all("R7 disabled");
        @(negedge clk) ext_en = 1'b1;
        repeat (4) @(negedge clk);

        // random traffic
        for (int n = 0; n < 60; n++) begin
            logic [11:0] h;
            logic [3:0]  a;
            logic [15:0] d;
            h = ($urandom_range(0, 4) == 0) ? 12'($urandom_range(2, 4095)) : 12'h001;
            a = 4'($urandom_range(0, 15));
            d = 16'($urandom);
            frame(mk(h, a, d));
            check_all("R2 random");
        end

        // R10: reset after writes
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R10 reset restore");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule